// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a segment-relative access into a flat linear address. A request names one of the cached segment slots, gives a 32-bit offset and says whether the access is a read, a write or an instruction fetch. The block picks that slot's 64-bit descriptor from a descriptor bank presented at its input. It pulls the scattered base, limit and flag fields out of the descriptor, checks the access against the segment's rights and size, and adds the base to the offset.

One clock edge after the request, the block presents either the linear address or a fault code, together with a valid flag. Loading descriptors into the bank is not part of this block. Paging and downward-growing segments are not part of it either.

Top module: `segx_xlate`

## Requirements
- R1: A request with `reqValid` high produces `resValid` high exactly one clock later. A cycle with no request produces `resValid`, `faultCode` and `linearAddr` all zero one clock later. All three are zero during reset.
- R2: On success, `linearAddr` equals the base plus the effective offset, modulo 2^32. The base is assembled as descriptor bits 63:56 over bits 39:16. Slot i's descriptor occupies `descBank[64*i+63:64*i]`.
- R3: The limit is assembled as descriptor bits 51:48 over bits 15:0. The granularity bit is bit 55. With granularity 0 the effective limit is the limit itself. With granularity 1 the effective limit is the limit followed by twelve one-bits.
- R4: The size bit is bit 54. With size 0, only offset bits 15:0 are used, zero-extended, for both the limit check and the sum. With size 1, all 32 offset bits are used.
- R5: An effective offset above the effective limit gives fault code 1 (limit). Whenever the fault code is non-zero, `linearAddr` is zero.
- R6: A descriptor whose present bit (bit 47) is 0 gives fault code 3 (absent).
- R7: A descriptor whose segment-kind bit (bit 44) is 0 gives fault code 2 (protection). So does a descriptor whose reserved bit 53 is set.
- R8: Type bits are 43:40. Bit 43 marks code and bit 41 marks a writable data segment. Access codes are 0 read, 1 write, 2 fetch and 3 reserved. The following give fault code 2: a write to code, a write to data with bit 41 clear, a fetch from data, and any access with code 3.
- R9: A slot number at or above `NUM_SEG` gives fault code 2.
- R10: Faults are prioritised as absent over protection, and protection over limit. A result with fault code 0 means the access succeeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| segSel | input | SEL_W | Segment slot number |
| offset | input | 32 | Segment-relative offset |
| accType | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| descBank | input | NUM_SEG*64 | Cached descriptors, slot i at bits 64*i+63:64*i |
| resValid | output | 1 | Result valid, one cycle after the request |
| linearAddr | output | 32 | Linear address, zero on fault |
| faultCode | output | 2 | 0 none, 1 limit, 2 protection, 3 absent |

## Verification
A single request can break a rights rule and the size rule in the same cycle. The protection and limit checks both run every cycle, and only one code can come out. The bench provokes this collision in two ways. It sweeps every type value and access kind against offsets just inside and just outside the effective limit, in all four granularity/size combinations. It also runs dedicated cases that pair an absent or system descriptor with an oversized offset. Each result is compared with a code derived from the fixed priority order: absent first, then protection, then limit. Because requests issue back to back, every capture also coincides with the presentation of the previous result.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_PROT   = 2'd2,
    FLT_ABSENT = 2'd3
  } faultE;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accE;

  // Unpacked view of one 64-bit descriptor
  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic        wide;
    logic        rsvd;
    logic        present;
    logic        normal;
    logic [3:0]  kind;
  } segFieldsT;

  // Control to datapath strobes
  typedef struct packed {
    logic  capture;
    faultE faultCode;
  } strobeT;

  localparam int DESC_W = 64;

endpackage

// File: rtl/segx_dpath.sv
module segx_dpath
  import segx_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [SEL_W-1:0]          segSel,
  input  logic [31:0]               offset,
  input  logic [NUM_SEG*DESC_W-1:0] descBank,
  input  strobeT                    strb,
  output segFieldsT                 fields,
  output logic                      selOk,
  output logic                      overLimit,
  output logic                      resValid,
  output logic [31:0]               linearAddr,
  output logic [1:0]                faultCode
);

  localparam int SLOTS = 1 << SEL_W;

  logic [DESC_W-1:0] descArr [SLOTS];
  logic [DESC_W-1:0] curDesc;
  logic [31:0]       effOffset;
  logic [31:0]       effLimit;
  logic [31:0]       sum;

  // Slice the bank into slots; unused slot numbers read as zero
  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    if (gi < NUM_SEG) begin : g_live
      assign descArr[gi] = descBank[gi*DESC_W +: DESC_W];
    end else begin : g_dead
      assign descArr[gi] = '0;
    end
  end

  assign selOk   = (32'(segSel) < NUM_SEG);
  assign curDesc = descArr[segSel];

  // Field extraction from the scattered layout
  always_comb begin
    fields.base    = {curDesc[63:56], curDesc[39:16]};
    fields.limit   = {curDesc[51:48], curDesc[15:0]};
    fields.gran    = curDesc[55];
    fields.wide    = curDesc[54];
    fields.rsvd    = curDesc[53];
    fields.present = curDesc[47];
    fields.normal  = curDesc[44];
    fields.kind    = curDesc[43:40];
  end

  assign effOffset = fields.wide ? offset : {16'b0, offset[15:0]};
  assign effLimit  = fields.gran ? {fields.limit, 12'hFFF} : {12'b0, fields.limit};
  assign overLimit = (effOffset > effLimit);
  assign sum       = fields.base + effOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      faultCode  <= FLT_NONE;
      linearAddr <= '0;
    end else begin
      resValid   <= strb.capture;
      faultCode  <= strb.capture ? strb.faultCode : FLT_NONE;
      linearAddr <= (strb.capture && strb.faultCode == FLT_NONE) ? sum : 32'b0;
    end
  end

endmodule

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
(
  input  logic      reqValid,
  input  logic [1:0] accType,
  input  segFieldsT fields,
  input  logic      selOk,
  input  logic      overLimit,
  output strobeT    strb
);

  logic isCode;
  logic writable;
  logic rightsBad;

  assign isCode   = fields.kind[3];
  assign writable = fields.kind[1];

  always_comb begin
    unique case (accE'(accType))
      ACC_READ:  rightsBad = 1'b0;
      ACC_WRITE: rightsBad = isCode || !writable;
      ACC_FETCH: rightsBad = !isCode;
      default:   rightsBad = 1'b1;
    endcase
  end

  always_comb begin
    strb.capture = reqValid;
    if (!selOk)
      strb.faultCode = FLT_PROT;
    else if (!fields.present)
      strb.faultCode = FLT_ABSENT;
    else if (!fields.normal || fields.rsvd || rightsBad)
      strb.faultCode = FLT_PROT;
    else if (overLimit)
      strb.faultCode = FLT_LIMIT;
    else
      strb.faultCode = FLT_NONE;
  end

endmodule

// File: rtl/segx_xlate.sv
module segx_xlate
  import segx_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [SEL_W-1:0]          segSel,
  input  logic [31:0]               offset,
  input  logic [1:0]                accType,
  input  logic [NUM_SEG*DESC_W-1:0] descBank,
  output logic                      resValid,
  output logic [31:0]               linearAddr,
  output logic [1:0]                faultCode
);

  segFieldsT fields;
  strobeT    strb;
  logic      selOk;
  logic      overLimit;

  segx_ctrl ctrl_i (
    .reqValid (reqValid),
    .accType  (accType),
    .fields   (fields),
    .selOk    (selOk),
    .overLimit(overLimit),
    .strb     (strb)
  );

  segx_dpath #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .segSel    (segSel),
    .offset    (offset),
    .descBank  (descBank),
    .strb      (strb),
    .fields    (fields),
    .selOk     (selOk),
    .overLimit (overLimit),
    .resValid  (resValid),
    .linearAddr(linearAddr),
    .faultCode (faultCode)
  );

endmodule

// File: rtl/segx_xlate_chk.sv
module segx_xlate_chk #(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic [SEL_W-1:0]      segSel,
  input logic [NUM_SEG*64-1:0] descBank,
  input logic                  resValid,
  input logic [31:0]           linearAddr,
  input logic [1:0]            faultCode
);

  logic prevReq, prevAbsent, prevBadSel;
  logic curPresent, curInRange;

  always_comb begin
    curPresent = 1'b1;
    curInRange = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (32'(segSel) == i) begin
        curPresent = descBank[64*i+47];
        curInRange = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReq    <= 1'b0;
      prevAbsent <= 1'b0;
      prevBadSel <= 1'b0;
    end else begin
      prevReq    <= reqValid;
      prevAbsent <= reqValid && curInRange && !curPresent;
      prevBadSel <= reqValid && !curInRange;
    end
  end

  // R1: result valid tracks the request one cycle earlier
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    resValid == prevReq);

  // R1: no result means quiet outputs
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (faultCode == 2'd0 && linearAddr == 32'd0));

  // R5: a faulting result carries no address
  a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode != 2'd0) |-> (linearAddr == 32'd0));

  // R6: absent descriptor reported as code 3
  a_r6_absent: assert property (@(posedge clk) disable iff (!rstN)
    prevAbsent |-> (resValid && faultCode == 2'd3));

  // R9: slot out of range reported as protection
  a_r9_bad_sel: assert property (@(posedge clk) disable iff (!rstN)
    prevBadSel |-> (resValid && faultCode == 2'd2));

endmodule

bind segx_xlate segx_xlate_chk #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .segSel    (segSel),
  .descBank  (descBank),
  .resValid  (resValid),
  .linearAddr(linearAddr),
  .faultCode (faultCode)
);

// File: tb/segx_xlate_tb_top.sv
module segx_xlate_tb_top;

  localparam int NS = 6;
  localparam int SW = 3;

  logic            clk = 1'b0;
  logic            rstN;
  logic            reqValid;
  logic [SW-1:0]   segSel;
  logic [31:0]     offset;
  logic [1:0]      accType;
  logic [NS*64-1:0] descBank;
  logic            resValid;
  logic [31:0]     linearAddr;
  logic [1:0]      faultCode;

  int nRun = 0;
  int nFail = 0;

  logic        pV;
  logic [31:0] pA;
  logic [1:0]  pF;
  string       pTag;

  always #5 clk = ~clk;

  segx_xlate #(.NUM_SEG(NS), .SEL_W(SW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .segSel(segSel),
    .offset(offset), .accType(accType), .descBank(descBank),
    .resValid(resValid), .linearAddr(linearAddr), .faultCode(faultCode)
  );

  function automatic logic [63:0] mkDesc(input logic [31:0] base, input logic [19:0] lim,
      input logic g, input logic d, input logic rsv, input logic p, input logic s,
      input logic [3:0] ty);
    logic [63:0] x;
    x = '0;
    x[63:56] = base[31:24];
    x[39:16] = base[23:0];
    x[51:48] = lim[19:16];
    x[15:0]  = lim[15:0];
    x[55] = g; x[54] = d; x[53] = rsv; x[47] = p; x[44] = s;
    x[43:40] = ty;
    return x;
  endfunction

  // Expected result from the requirement text
  task automatic model(input logic [63:0] d, input int sel, input logic [1:0] acc,
      input logic [31:0] off, output logic [31:0] a, output logic [1:0] f);
    logic [31:0] base, eo, el;
    logic bad;
    a = 0;
    base = {d[63:56], d[39:16]};
    eo = d[54] ? off : {16'b0, off[15:0]};
    el = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'b0, d[51:48], d[15:0]};
    bad = (acc == 2'd3) || (acc == 2'd1 && (d[43] || !d[41])) || (acc == 2'd2 && !d[43]);
    if (sel >= NS) f = 2'd2;
    else if (!d[47]) f = 2'd3;
    else if (!d[44] || d[53] || bad) f = 2'd2;
    else if (eo > el) f = 2'd1;
    else begin f = 2'd0; a = base + eo; end
  endtask

  task automatic checkNow();
    nRun++;
    if (resValid !== pV || faultCode !== pF || linearAddr !== pA) begin
      nFail++;
      $display("FAIL %s: got v=%0b f=%0d a=%h, expected v=%0b f=%0d a=%h",
               pTag, resValid, faultCode, linearAddr, pV, pF, pA);
    end
  endtask

  // Check previous result, then drive a new request (back to back)
  task automatic step(input logic v, input int sel, input logic [1:0] acc,
      input logic [31:0] off, input logic [63:0] d, input string tag);
    @(negedge clk);
    checkNow();
    if (sel < NS) descBank[64*sel +: 64] = d;
    reqValid = v;
    segSel   = SW'(sel);
    accType  = acc;
    offset   = off;
    pTag = tag;
    pV = v;
    if (v) model(d, sel, acc, off, pA, pF);
    else begin pA = 0; pF = 0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [19:0] lim;
    logic [31:0] base, eff, off;
    int cnt;
    rstN = 1'b0; reqValid = 0; segSel = 0; offset = 0; accType = 0; descBank = '0;
    pV = 0; pA = 0; pF = 0; pTag = "R1 reset";
    repeat (3) @(negedge clk);
    checkNow();                        // R1 reset state
    rstN = 1'b1;

    lim = 20'h01234; base = 32'h1000_0F00; cnt = 0;
    // R2 R3 R4 R5 R8 sweep over flags, types, accesses, offsets
    for (int g = 0; g < 2; g++)
      for (int df = 0; df < 2; df++)
        for (int ty = 0; ty < 16; ty++)
          for (int acc = 0; acc < 4; acc++)
            for (int k = 0; k < 4; k++) begin
              eff = g ? {lim, 12'hFFF} : {12'b0, lim};
              case (k)
                0: off = 32'h0000_0100;
                1: off = eff;
                2: off = eff + 1;
                default: off = 32'hABCD_0010;
              endcase
              step(1'b1, cnt % NS, 2'(acc), off,
                   mkDesc(base + 32'(cnt), lim, 1'(g), 1'(df), 1'b0, 1'b1, 1'b1, 4'(ty)),
                   "R2 R3 R4 R5 R8 sweep");
              cnt++;
              if (cnt % 37 == 0) step(1'b0, 0, 0, 0, 64'd0, "R1 idle gap");
            end

    // R2 wrap-around of the sum
    step(1, 2, 0, 32'h0000_2000, mkDesc(32'hFFFF_F000, 20'hFFFFF, 1, 1, 0, 1, 1, 4'h2), "R2 wrap");
    // R6 absent, and R10 absent beats protection and limit
    for (int acc = 0; acc < 4; acc++) begin
      step(1, 1, 2'(acc), 32'h10, mkDesc(32'h100, 20'h10, 0, 1, 0, 0, 1, 4'h2), "R6 absent");
      step(1, 3, 2'(acc), 32'hFFFF_FFFF, mkDesc(32'h100, 20'h10, 0, 1, 1, 0, 0, 4'h8), "R10 absent first");
    end
    // R7 system descriptor and reserved bit; R10 protection beats limit
    step(1, 0, 0, 32'h4, mkDesc(32'h200, 20'h10, 0, 1, 0, 1, 0, 4'h2), "R7 system kind");
    step(1, 4, 0, 32'h4, mkDesc(32'h200, 20'h10, 0, 1, 1, 1, 1, 4'h2), "R7 reserved bit");
    step(1, 5, 1, 32'h9999, mkDesc(32'h200, 20'h10, 0, 1, 0, 1, 1, 4'h0), "R10 prot over limit");
    step(1, 5, 0, 32'h9999, mkDesc(32'h200, 20'h10, 0, 1, 0, 1, 1, 4'h0), "R10 limit alone");
    // R9 slot numbers past the bank
    step(1, 6, 0, 32'h0, 64'd0, "R9 slot 6");
    step(1, 7, 2, 32'h0, 64'd0, "R9 slot 7");
    step(0, 0, 0, 0, 64'd0, "R1 final idle");
    step(0, 0, 0, 0, 64'd0, "R1 final idle");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule